// File: doc/BRIEF.md
# Calendar Clock Register Bank

This block holds a calendar clock as eight byte-wide registers in packed BCD: century, year, month, date, day of week, hour, minute and second. The registers occupy the top eight byte addresses of an asynchronous-style SRAM bus with active-low chip enable, output enable and write enable. That bus is sampled here on the system clock. A one-cycle pulse on `tick` advances the clock by one second. Every carry is handled in BCD, including month lengths and leap years.

Bits with no time meaning are either control and status flags or plain storage. One flag stops the oscillator. A second freezes the readable image so that a multi-byte read stays coherent while counting goes on underneath. A third suspends counting so that software can set a new time, which is loaded when that flag is cleared. The day register also reports a battery-low status input.

Top module: `rtc_regbank`

## Requirements
- R1: Only addresses whose upper bits (all but the low three) are all ones select the bank. The low three bits pick the register: 0 century, 1 second, 2 minute, 3 hour, 4 day, 5 date, 6 month, 7 year. A read at any other address leaves `dout_en` low.
- R2: `dout_en` is 1 only while `ce_n`=0, `oe_n`=0, `we_n`=1 and the address selects the bank. `dout` is 0 whenever `dout_en` is 0. The read value follows the address with no clock delay.
- R3: A write cycle lasts while `ce_n` and `we_n` are both low. It takes effect at the first clock edge after either signal rises, using the address and data sampled in the last clock cycle of the write.
- R4: Each accepted tick advances the seconds. Seconds and minutes wrap from 59 to 00 with a carry, and hours wrap from 23 to 00 with a carry into the day.
- R5: A day carry moves the day of week from 07 to 01 (otherwise adds 1) and advances the date. Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century. Century 39 wraps to 00.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, after 31 in the other long months, and after 28 or 29 in month 02. A year is leap when it is a multiple of 4. Year 00 is leap only when the century is a multiple of 4.
- R7: Bits outside the time fields store and return what was written. Those are bit 7 of the minute register, bits 7:6 of hour and date, bits 5:3 of day, and bits 7:5 of month.
- R8: While bit 7 of the second register (oscillator stop) is 1, ticks are ignored.
- R9: While bit 6 of the century register (read hold) is 1, the readable time fields do not change, but counting continues. The readable time catches up with the counters within one cycle after the bit is cleared.
- R10: While bit 7 of the century register (set hold) is 1, ticks are ignored and writes change only the readable image. The write that clears the bit loads the time fields of the image into the counters.
- R11: Bit 7 of the day register always reads as the `batt_low` input, and writes to that bit have no visible effect.
- R12: After reset the bank reads century 00, year 00, month 01, date 01, day 01, and 00:00:00, with all flags and spare bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse per second |
| batt_low | input | 1 | Battery-low status, reported in the day register |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Bus drive enable |

## Verification
The block's internal state is the counter set and the readable image. A wrong carry or month length stays hidden until the following tick, and then shows up in the first read of the affected register. The bench therefore loads times just before each boundary, gives one tick, and reads back all eight registers. A freeze flag that fails to hold or release shows up within one or two cycles as a second value that changes or does not change when it should. A stuck bus decode shows up at once on `dout_en`.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] date;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] minute;
        logic [7:0] second;
        logic [7:0] century;
    } rtc_time_t;

    localparam int NREG = 8;

    function automatic logic [7:0] time_mask(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'h3F;
            3'd1:    return 8'h7F;
            3'd2:    return 8'h7F;
            3'd3:    return 8'h3F;
            3'd4:    return 8'h07;
            3'd5:    return 8'h3F;
            3'd6:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

endpackage

// File: rtl/rtc_bus_port.sv
`timescale 1ns/1ps
module rtc_bus_port #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              rd_en,
    output logic [2:0]        rd_idx,
    output logic              wr_commit,
    output logic [2:0]        wr_idx,
    output logic [7:0]        wr_data
);
    localparam int HI_W = ADDR_W - 3;

    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } cap_t;

    cap_t cap_d, cap_q;
    logic wr_act;

    always_comb begin
        wr_act     = !ce_n && !we_n;
        cap_d      = cap_q;
        cap_d.act  = wr_act;
        if (wr_act) begin
            cap_d.addr = addr;
            cap_d.data = din;
        end
        rd_en     = !ce_n && !oe_n && we_n && (addr[ADDR_W-1:3] == {HI_W{1'b1}});
        rd_idx    = addr[2:0];
        wr_commit = cap_q.act && !wr_act && (cap_q.addr[ADDR_W-1:3] == {HI_W{1'b1}});
        wr_idx    = cap_q.addr[2:0];
        wr_data   = cap_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end
endmodule

// File: rtl/rtc_calendar_next.sv
`timescale 1ns/1ps
module rtc_calendar_next
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      step,
    output rtc_time_t nxt
);
    logic [6:0] yr_bin, cen_bin;
    logic       leap;
    logic [7:0] last_date;

    always_comb begin
        yr_bin  = bcd_to_bin(cur.year);
        cen_bin = bcd_to_bin(cur.century);
        leap    = (yr_bin == 7'd0) ? (cen_bin[1:0] == 2'd0) : (yr_bin[1:0] == 2'd0);
        if (cur.month == 8'h02)
            last_date = leap ? 8'h29 : 8'h28;
        else if (cur.month == 8'h04 || cur.month == 8'h06 ||
                 cur.month == 8'h09 || cur.month == 8'h11)
            last_date = 8'h30;
        else
            last_date = 8'h31;

        nxt = cur;
        if (step) begin
            nxt.second = bcd_inc(cur.second);
            if (cur.second == 8'h59) begin
                nxt.second = 8'h00;
                nxt.minute = bcd_inc(cur.minute);
                if (cur.minute == 8'h59) begin
                    nxt.minute = 8'h00;
                    nxt.hour   = bcd_inc(cur.hour);
                    if (cur.hour == 8'h23) begin
                        nxt.hour = 8'h00;
                        nxt.day  = (cur.day == 8'h07) ? 8'h01 : bcd_inc(cur.day);
                        nxt.date = bcd_inc(cur.date);
                        if (cur.date == last_date) begin
                            nxt.date  = 8'h01;
                            nxt.month = bcd_inc(cur.month);
                            if (cur.month == 8'h12) begin
                                nxt.month = 8'h01;
                                nxt.year  = bcd_inc(cur.year);
                                if (cur.year == 8'h99) begin
                                    nxt.year    = 8'h00;
                                    nxt.century = (cur.century == 8'h39) ? 8'h00
                                                                         : bcd_inc(cur.century);
                                end
                            end
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_regbank.sv
`timescale 1ns/1ps
module rtc_regbank
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              batt_low,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);
    localparam logic [63:0] RESET_IMG = 64'h00_01_01_01_00_00_00_00;

    typedef struct packed {
        logic [NREG-1:0][7:0] cnt;
        logic [NREG-1:0][7:0] img;
    } bank_t;

    bank_t      st_d, st_q;
    logic       rd_en, wr_commit;
    logic [2:0] rd_idx, wr_idx;
    logic [7:0] wr_data;
    logic       set_hold, read_hold, osc_stop, step;
    rtc_time_t  cur_time, adv_time;

    rtc_bus_port #(.ADDR_W(ADDR_W)) bus_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .rd_en(rd_en), .rd_idx(rd_idx),
        .wr_commit(wr_commit), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    assign cur_time = st_q.cnt;

    rtc_calendar_next cal_i (.cur(cur_time), .step(step), .nxt(adv_time));

    always_comb begin
        set_hold  = st_q.img[0][7];
        read_hold = st_q.img[0][6];
        osc_stop  = st_q.img[1][7];
        step      = tick && !osc_stop && !set_hold;

        st_d     = st_q;
        st_d.cnt = set_hold ? st_q.cnt : adv_time;
        if (wr_commit) begin
            st_d.img[wr_idx] = wr_data;
            if (!set_hold)
                st_d.cnt[wr_idx] = wr_data & time_mask(wr_idx);
            else if (wr_idx == 3'd0 && !wr_data[7])
                for (int i = 0; i < NREG; i++)
                    st_d.cnt[i] = st_d.img[i] & time_mask(3'(i));
        end
        if (!set_hold && !read_hold)
            for (int i = 0; i < NREG; i++)
                st_d.img[i] = (st_d.img[i] & ~time_mask(3'(i))) | st_d.cnt[i];

        dout_en = rd_en;
        dout    = 8'h00;
        if (rd_en) begin
            dout = st_q.img[rd_idx];
            if (rd_idx == 3'd4) dout[7] = batt_low;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= RESET_IMG;
            st_q.img <= RESET_IMG;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rtc_regbank_chk.sv
`timescale 1ns/1ps
module rtc_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        ce_n,
    input logic        oe_n,
    input logic        we_n,
    input logic [7:0]  dout,
    input logic        dout_en,
    input logic        wr_commit,
    input logic [63:0] cnt_q,
    input logic [63:0] img_q
);
    // R2: bus driven only in a read cycle
    a_r2_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!ce_n && !oe_n && we_n));

    // R2: undriven bus reads zero
    a_r2_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == 8'h00));

    // R8: oscillator stop freezes counters
    a_r8_osc_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (img_q[15] && !wr_commit) |=> $stable(cnt_q));

    // R10: set hold freezes counters
    a_r10_set_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (img_q[7] && !wr_commit) |=> $stable(cnt_q));

    // R9: read hold freezes readable image
    a_r9_read_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (img_q[6] && !wr_commit) |=> $stable(img_q));

    // R4: an accepted tick moves the seconds
    a_r4_second_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !img_q[15] && !img_q[7] && !wr_commit)
        |=> (cnt_q[15:8] != $past(cnt_q[15:8])));
endmodule

bind rtc_regbank rtc_regbank_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .dout(dout), .dout_en(dout_en), .wr_commit(wr_commit),
    .cnt_q(st_q.cnt), .img_q(st_q.img)
);

// File: tb/rtc_regbank_tb.sv
`timescale 1ns/1ps
module rtc_regbank_tb_top;
    localparam int AW = 19;
    localparam logic [AW-1:0] BASE = {AW{1'b1}} << 3;
    localparam int NV = 10;
    // {start image, image after one tick}; bytes year,month,date,day,hour,min,sec,century
    localparam logic [127:0] VEC [NV] = '{
        {64'h24_02_28_03_23_59_59_20, 64'h24_02_29_04_00_00_00_20},
        {64'h23_02_28_07_23_59_59_20, 64'h23_03_01_01_00_00_00_20},
        {64'h00_02_28_01_23_59_59_19, 64'h00_03_01_02_00_00_00_19},
        {64'h00_02_28_01_23_59_59_20, 64'h00_02_29_02_00_00_00_20},
        {64'h24_04_30_02_23_59_59_20, 64'h24_05_01_03_00_00_00_20},
        {64'h99_12_31_05_23_59_59_39, 64'h00_01_01_06_00_00_00_00},
        {64'h24_06_15_06_12_34_56_20, 64'h24_06_15_06_12_34_57_20},
        {64'h24_06_15_06_10_59_59_20, 64'h24_06_15_06_11_00_00_20},
        {64'h99_12_31_07_23_59_59_20, 64'h00_01_01_01_00_00_00_21},
        {64'h24_01_31_03_23_59_59_20, 64'h24_02_01_04_00_00_00_20}
    };

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, batt_low = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0, dout, rdata;
    logic dout_en, rd_drv;
    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    rtc_regbank #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .batt_low(batt_low),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        addr = BASE | AW'(idx); din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(posedge clk);
    endtask

    task automatic rd_at(input logic [AW-1:0] a, input logic oe);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = oe; we_n = 1'b1;
        #1;
        rdata = dout; rd_drv = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd(input logic [2:0] idx);
        rd_at(BASE | AW'(idx), 1'b0);
    endtask

    task automatic pulse(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic load(input logic [63:0] img);
        wr(3'd0, 8'h80 | img[7:0]);
        for (int i = 1; i < 8; i++) wr(3'(i), img[i*8 +: 8]);
        wr(3'd0, img[7:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R12: reset image
        for (int i = 0; i < 8; i++) begin
            rd(3'(i));
            check("R12 reset", rdata, (i == 4 || i == 5 || i == 6) ? 8'h01 : 8'h00);
        end
        // R4 R5 R6: boundary vectors
        for (int v = 0; v < NV; v++) begin
            load(VEC[v][127:64]);
            pulse(1);
            for (int i = 0; i < 8; i++) begin
                rd(3'(i));
                check($sformatf("R4 R5 R6 vec%0d reg%0d", v, i), rdata, VEC[v][i*8 +: 8]);
            end
        end
        // R9: read hold
        load(64'h24_06_15_06_12_34_56_20);
        wr(3'd0, 8'h60);
        pulse(3);
        rd(3'd1); check("R9 held second", rdata, 8'h56);
        wr(3'd0, 8'h20);
        @(negedge clk); @(negedge clk);
        rd(3'd1); check("R9 released second", rdata, 8'h59);
        // R8: oscillator stop
        wr(3'd1, 8'h90);
        pulse(3);
        rd(3'd1); check("R8 stopped second", rdata, 8'h90);
        wr(3'd1, 8'h10);
        pulse(1);
        rd(3'd1); check("R8 restarted second", rdata, 8'h11);
        // R7: spare bits
        wr(3'd2, 8'hA5);
        wr(3'd5, 8'hC5);
        pulse(1);
        rd(3'd2); check("R7 minute spare", rdata, 8'hA5);
        rd(3'd5); check("R7 date spare", rdata, 8'hC5);
        rd(3'd1); check("R7 seconds still count", rdata, 8'h12);
        // R10: set hold and transfer
        wr(3'd0, 8'hA0);
        pulse(2);
        rd(3'd1); check("R10 held second", rdata, 8'h12);
        wr(3'd1, 8'h30);
        rd(3'd1); check("R10 staged second", rdata, 8'h30);
        wr(3'd0, 8'h20);
        pulse(1);
        rd(3'd1); check("R10 transferred second", rdata, 8'h31);
        // R11: battery flag
        batt_low = 1'b1;
        rd(3'd4); check("R11 flag set", rdata, 8'h86);
        wr(3'd4, 8'h83);
        batt_low = 1'b0;
        rd(3'd4); check("R11 write ignored", rdata, 8'h03);
        // R3: last sampled data wins
        @(negedge clk);
        addr = BASE | AW'(2); din = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk); din = 8'h22;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        @(posedge clk);
        rd(3'd2); check("R3 end-of-cycle data", rdata, 8'h22);
        // R2: no drive without output enable
        rd_at(BASE | AW'(2), 1'b1);
        check("R2 oe high enable", {7'd0, rd_drv}, 8'h00);
        check("R2 oe high data", rdata, 8'h00);
        // R1: outside the bank
        rd_at('0, 1'b0);
        check("R1 low address enable", {7'd0, rd_drv}, 8'h00);
        rd(3'd7);
        check("R1 bank enable", {7'd0, rd_drv}, 8'h01);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule